// File: doc/BRIEF.md
# Framebuffer Memory Overlay Mapper

This block sits on the CPU memory path. It decides, for each access, whether the access goes to a 48 KB bitmap framebuffer held elsewhere in physical memory or to the ordinary memory map. It holds three registers that the CPU writes through I/O ports. The first is a control byte. The other two are bank-base registers, one for the active framebuffer and one for the shadow framebuffer. For a framebuffer access the block produces a 21-bit physical address. Otherwise the CPU address passes through unchanged.

Software can enable the read overlay and the write overlay separately. A common use is to let writes land in the framebuffer while reads still return code and data from normal memory. The overlay covers either one 16 KB third of the framebuffer at CPU addresses 0x0000–0x3FFF, or all three thirds at 0x0000–0xBFFF. A control bit chooses between the active and the shadow buffer. Either buffer can begin at any of the 128 physical 16 KB banks. A separate control bit drives the display enable, and it does not touch the overlay.

The decode from CPU address to physical address is purely combinational. A register write takes effect from the clock edge that captures it.

Top module: `fbov_mapper`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads as 0x00 and disp_en is low. The active base reads as RST_ACT_BANK and the shadow base reads as RST_SHD_BANK. No CPU access selects the framebuffer.
- R2: A write to I/O port 0x123B stores the control byte. Bits, MSB first, are: mode[1:0] at bits 7:6, reserved at bits 5:4, shadow select at bit 3, read enable at bit 2, display enable at bit 1, write enable at bit 0. Reading port 0x123B returns the stored byte with bits 5:4 as zero.
- R3: disp_en equals control bit 1. That bit has no effect on fb_sel or phys_addr.
- R4: With control bit 0 set, a CPU write (cpu_wr high) inside the overlaid range raises fb_sel. With only bit 0 set, a CPU read (cpu_rd high, cpu_wr low) keeps fb_sel low.
- R5: With control bit 2 set, a CPU read inside the overlaid range raises fb_sel. Bits 0 and 2 may be set together, and each then covers its own strobe.
- R6: With mode 00, 01 or 10, only CPU addresses 0x0000–0x3FFF are overlaid. The segment index equals the mode value.
- R7: With mode 11, CPU addresses 0x0000–0xBFFF are overlaid with segment index cpu_addr[15:14]. Addresses 0xC000–0xFFFF are never overlaid.
- R8: Control bit 3 set selects the shadow base register. Bit 3 clear selects the active base register.
- R9: A write to port 0x123C (active) or 0x123D (shadow) stores data bits 6:0 as a bank number from 0 to 127. Reading the port returns that bank number with bit 7 zero. For a framebuffer access, phys_addr = (((base + segment) mod 128) << 14) | cpu_addr[13:0].
- R10: When fb_sel is low, phys_addr equals cpu_addr zero-extended to 21 bits.
- R11: An I/O write to any other port changes none of the registers. fb_sel is low whenever neither cpu_rd nor cpu_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address, for both write and read-back |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read-back of the register addressed by io_addr, zero for other ports |
| cpu_addr | input | 16 | CPU memory address |
| cpu_rd | input | 1 | CPU memory read strobe |
| cpu_wr | input | 1 | CPU memory write strobe |
| fb_sel | output | 1 | Access is routed to framebuffer memory |
| phys_addr | output | 21 | Physical address |
| disp_en | output | 1 | Framebuffer display enable |

## Verification
A corrupted control or base register shows on the ports in the same cycle as the next CPU access it affects. The symptoms are a wrong fb_sel, a phys_addr pointing at the wrong bank, or a disp_en that does not match the last control write. Because every register can be read back combinationally, a bad stored value can also be seen on io_rdata one cycle after the write that should have set it. The bench therefore reads all three registers back after every port write. It then compares each CPU access against a model that tracks the same writes. Any divergence is caught at the first access whose mode, strobe or bank it disturbs.

// File: rtl/fbov_pkg.sv
// Package fbov_pkg
// Shared types for the framebuffer overlay mapper.
// Assumes the framebuffer is three segments, each one CPU window in size.
package fbov_pkg;

    // Which part of the framebuffer the overlay exposes.
    typedef enum logic [1:0] {
        SEG_FIRST  = 2'd0,
        SEG_SECOND = 2'd1,
        SEG_THIRD  = 2'd2,
        SEG_ALL    = 2'd3
    } seg_mode_e;

    // Control byte; field order fixes the bit position of each field.
    typedef struct packed {
        seg_mode_e  mode;     // bits 7:6
        logic [1:0] rsvd;     // bits 5:4, always stored as zero
        logic       shadow;   // bit 3
        logic       rd_en;    // bit 2
        logic       disp;     // bit 1
        logic       wr_en;    // bit 0
    } ctrl_t;

endpackage

// File: rtl/fbov_regs.sv
// Module fbov_regs
// Holds the control byte and the two framebuffer bank-base registers.
// Writes are captured on the clock edge; read-back is combinational.
// Assumes BANK_W <= 8 so that a bank number fits the read-back byte.
module fbov_regs
    import fbov_pkg::*;
#(
    parameter int                  ADDR_W       = 16,
    parameter int                  BANK_W       = 7,
    parameter logic [ADDR_W-1:0]   CTRL_PORT    = 16'h123B,
    parameter logic [ADDR_W-1:0]   ACT_PORT     = 16'h123C,
    parameter logic [ADDR_W-1:0]   SHD_PORT     = 16'h123D,
    parameter logic [BANK_W-1:0]   RST_ACT_BANK = 7'd9,
    parameter logic [BANK_W-1:0]   RST_SHD_BANK = 7'd12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output seg_mode_e         mode,
    output logic              shadow,
    output logic              rd_en,
    output logic              wr_en,
    output logic              disp,
    output logic [BANK_W-1:0] bank_act,
    output logic [BANK_W-1:0] bank_shd
);

    localparam int NBUF = 2;

    ctrl_t             ctrl_q;
    ctrl_t             ctrl_nxt;
    logic [BANK_W-1:0] bank_w [NBUF];

    // Form the next control value with the reserved bits forced to zero.
    always_comb begin
        ctrl_nxt      = ctrl_t'(io_wdata);
        ctrl_nxt.rsvd = 2'b00;
    end

    // Capture a control write, or clear the byte on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (io_wr && io_addr == CTRL_PORT)
            ctrl_q <= ctrl_nxt;
    end

    // One bank-base register per buffer: 0 is active, 1 is shadow.
    for (genvar i = 0; i < NBUF; i++) begin : g_bank
        localparam logic [ADDR_W-1:0] PORT_I = (i == 0) ? ACT_PORT : SHD_PORT;
        localparam logic [BANK_W-1:0] RST_I  = (i == 0) ? RST_ACT_BANK : RST_SHD_BANK;
        logic [BANK_W-1:0] q;

        // Capture a bank write for this buffer, or load the default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_I;
            else if (io_wr && io_addr == PORT_I)
                q <= io_wdata[BANK_W-1:0];
        end

        assign bank_w[i] = q;
    end

    assign bank_act = bank_w[0];
    assign bank_shd = bank_w[1];
    assign mode     = ctrl_q.mode;
    assign shadow   = ctrl_q.shadow;
    assign rd_en    = ctrl_q.rd_en;
    assign wr_en    = ctrl_q.wr_en;
    assign disp     = ctrl_q.disp;

    // Return the addressed register, or zero for any other port.
    always_comb begin
        if (io_addr == CTRL_PORT)
            io_rdata = ctrl_q;
        else if (io_addr == ACT_PORT)
            io_rdata = 8'(bank_w[0]);
        else if (io_addr == SHD_PORT)
            io_rdata = 8'(bank_w[1]);
        else
            io_rdata = 8'h00;
    end

    // R1: the first cycle out of reset sees a cleared control byte.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == '0));

    // R2: the reserved bits never read back as one.
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == CTRL_PORT) |-> (io_rdata[5:4] == 2'b00));

    // R3: the display enable follows the written bit from the next cycle.
    p_disp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == CTRL_PORT) |=> (disp == $past(io_wdata[1])));

    // R11: a write to an unrelated port leaves every register unchanged.
    p_other_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr != CTRL_PORT && io_addr != ACT_PORT && io_addr != SHD_PORT)
        |=> ($stable(ctrl_q) && $stable(bank_act) && $stable(bank_shd)));

endmodule

// File: rtl/fbov_decode.sv
// Module fbov_decode
// Combinational access decode: range test, strobe gating, segment pick and
// physical address build. Assumes ADDR_W = SEG_W + 2, so the CPU space is
// four windows and the framebuffer fills at most three of them.
module fbov_decode
    import fbov_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 14,
    parameter int BANK_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seg_mode_e                mode,
    input  logic                     shadow,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [BANK_W-1:0]        bank_act,
    input  logic [BANK_W-1:0]        bank_shd,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic                     fb_sel,
    output logic [BANK_W+SEG_W-1:0]  phys_addr
);

    localparam int PHYS_W = BANK_W + SEG_W;
    localparam int WIN_W  = ADDR_W - SEG_W;

    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  seg_idx;
    logic              in_range;
    logic              strobe_ok;
    logic [BANK_W-1:0] base;
    logic [BANK_W-1:0] bank;

    assign win = cpu_addr[ADDR_W-1:SEG_W];

    // Decide which windows are overlaid and which segment each one shows.
    always_comb begin
        if (mode == SEG_ALL) begin
            in_range = (win != '1);
            seg_idx  = win;
        end else begin
            in_range = (win == '0);
            seg_idx  = WIN_W'(mode);
        end
    end

    // Gate the overlay by the enable that matches the access strobe.
    assign strobe_ok = (cpu_rd && rd_en) || (cpu_wr && wr_en);
    assign fb_sel    = strobe_ok && in_range;

    // Pick the buffer base and add the segment, wrapping in bank space.
    assign base = shadow ? bank_shd : bank_act;
    assign bank = base + BANK_W'(seg_idx);

    // Drive the framebuffer address or pass the CPU address through.
    always_comb begin
        if (fb_sel)
            phys_addr = {bank, cpu_addr[SEG_W-1:0]};
        else
            phys_addr = PHYS_W'(cpu_addr);
    end

    // R4: a read with the read overlay off never reaches the framebuffer.
    p_no_read_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !rd_en) |-> !fb_sel);

    // R6: in single-segment modes nothing above the first window is overlaid.
    p_single_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SEG_ALL && win != '0) |-> !fb_sel);

    // R7: the top window is never overlaid.
    p_top_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win == '1) |-> !fb_sel);

    // R9: the offset inside a bank always comes from the CPU address.
    p_offset_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_sel |-> (phys_addr[SEG_W-1:0] == cpu_addr[SEG_W-1:0]));

    // R11: with no strobe there is no framebuffer access.
    p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> !fb_sel);

endmodule

// File: rtl/fbov_mapper.sv
// Module fbov_mapper
// Top of the framebuffer overlay mapper: register block plus access decode.
// Assumes the surrounding paging logic uses phys_addr only when fb_sel is high,
// and otherwise takes the passed-through CPU address.
module fbov_mapper
    import fbov_pkg::*;
#(
    parameter int                  ADDR_W       = 16,
    parameter int                  SEG_W        = 14,
    parameter int                  BANK_W       = 7,
    parameter logic [ADDR_W-1:0]   CTRL_PORT    = 16'h123B,
    parameter logic [ADDR_W-1:0]   ACT_PORT     = 16'h123C,
    parameter logic [ADDR_W-1:0]   SHD_PORT     = 16'h123D,
    parameter logic [BANK_W-1:0]   RST_ACT_BANK = 7'd9,
    parameter logic [BANK_W-1:0]   RST_SHD_BANK = 7'd12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic                     io_wr,
    input  logic [7:0]               io_wdata,
    output logic [7:0]               io_rdata,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic                     fb_sel,
    output logic [BANK_W+SEG_W-1:0]  phys_addr,
    output logic                     disp_en
);

    localparam int PHYS_W = BANK_W + SEG_W;

    seg_mode_e         mode;
    logic              shadow;
    logic              rd_en;
    logic              wr_en;
    logic [BANK_W-1:0] bank_act;
    logic [BANK_W-1:0] bank_shd;

    // Register block: control byte and bank bases.
    fbov_regs #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .CTRL_PORT(CTRL_PORT), .ACT_PORT(ACT_PORT), .SHD_PORT(SHD_PORT),
        .RST_ACT_BANK(RST_ACT_BANK), .RST_SHD_BANK(RST_SHD_BANK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mode(mode), .shadow(shadow), .rd_en(rd_en), .wr_en(wr_en), .disp(disp_en),
        .bank_act(bank_act), .bank_shd(bank_shd)
    );

    // Access decode: select flag and physical address.
    fbov_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .BANK_W(BANK_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .mode(mode), .shadow(shadow), .rd_en(rd_en), .wr_en(wr_en),
        .bank_act(bank_act), .bank_shd(bank_shd),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .fb_sel(fb_sel), .phys_addr(phys_addr)
    );

    // R10: a non-framebuffer access keeps its CPU address.
    p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_sel |-> (phys_addr == PHYS_W'(cpu_addr)));

endmodule

// File: tb/test_fbov_mapper.sv
module test_fbov_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        fb_sel;
    logic [20:0] phys_addr;
    logic        disp_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_ctrl;
    logic [6:0] m_act;
    logic [6:0] m_shd;

    always #5 clk = ~clk;

    fbov_mapper i_fbov_mapper (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .fb_sel(fb_sel), .phys_addr(phys_addr), .disp_en(disp_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected select flag and physical address, from the requirements.
    function automatic logic [21:0] model(input logic [15:0] a, input logic rd, input logic wr);
        logic [1:0] md  = m_ctrl[7:6];
        logic [1:0] win = a[15:14];
        logic       inr = (md == 2'd3) ? (win != 2'd3) : (win == 2'd0);
        logic [1:0] seg = (md == 2'd3) ? win : md;
        logic       en  = (rd && m_ctrl[2]) || (wr && m_ctrl[0]);
        logic [6:0] bs  = m_ctrl[3] ? m_shd : m_act;
        logic [6:0] bk  = bs + 7'(seg);
        if (en && inr) return {1'b1, bk, a[13:0]};
        return {1'b0, 5'd0, a};
    endfunction

    task automatic io_write(input logic [15:0] port, input logic [7:0] d);
        @(negedge clk);
        io_addr = port; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (port == 16'h123B) m_ctrl = {d[7:6], 2'b00, d[3:0]};
        else if (port == 16'h123C) m_act = d[6:0];
        else if (port == 16'h123D) m_shd = d[6:0];
    endtask

    task automatic readback(input string req);
        io_addr = 16'h123B; #1; chk({req, " ctrl readback"}, 32'(io_rdata), 32'(m_ctrl));
        io_addr = 16'h123C; #1; chk({req, " act readback"}, 32'(io_rdata), 32'(m_act));
        io_addr = 16'h123D; #1; chk({req, " shd readback"}, 32'(io_rdata), 32'(m_shd));
        chk({req, " disp_en"}, 32'(disp_en), 32'(m_ctrl[1]));
    endtask

    task automatic access(input string req, input logic [15:0] a, input logic rd, input logic wr);
        logic [21:0] e;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #1;
        e = model(a, rd, wr);
        chk({req, " fb_sel"}, 32'(fb_sel), 32'(e[21]));
        chk({req, " phys_addr"}, 32'(phys_addr), 32'(e[20:0]));
        #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = 8'h00; m_act = 7'd9; m_shd = 7'd12;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and no overlay.
        readback("R1");
        access("R1", 16'h0123, 1'b1, 1'b0);
        access("R1", 16'h1000, 1'b0, 1'b1);

        // R2: reserved bits read back as zero.
        io_write(16'h123B, 8'hFF);
        readback("R2");
        io_addr = 16'h123B; #1;
        chk("R2 rsvd bits", 32'(io_rdata[5:4]), 32'd0);

        // R3: display bit alone gives no overlay.
        io_write(16'h123B, 8'h02);
        chk("R3 disp_en set", 32'(disp_en), 32'd1);
        access("R3", 16'h0100, 1'b1, 1'b0);
        chk("R3 no overlay", 32'(fb_sel), 32'd0);
        access("R3", 16'h0100, 1'b0, 1'b1);

        // R4: write-only overlay.
        io_write(16'h123B, 8'h01);
        access("R4 write", 16'h2345, 1'b0, 1'b1);
        chk("R4 write mapped", 32'(phys_addr), 32'(21'h24000 | 21'h2345));
        access("R4 read", 16'h2345, 1'b1, 1'b0);

        // R5: read overlay, then both together.
        io_write(16'h123B, 8'h04);
        access("R5 read", 16'h3FFF, 1'b1, 1'b0);
        access("R5 write off", 16'h3FFF, 1'b0, 1'b1);
        io_write(16'h123B, 8'h05);
        access("R5 both rd", 16'h0000, 1'b1, 1'b0);
        access("R5 both wr", 16'h0001, 1'b0, 1'b1);

        // R6: third selection and range edge.
        io_write(16'h123B, 8'h85);
        access("R6 third", 16'h3FFF, 1'b1, 1'b0);
        chk("R6 bank", 32'(phys_addr[20:14]), 32'd11);
        access("R6 out", 16'h4000, 1'b1, 1'b0);

        // R7: all segments, edges.
        io_write(16'h123B, 8'hC5);
        access("R7 win2", 16'hBFFF, 1'b0, 1'b1);
        chk("R7 bank", 32'(phys_addr[20:14]), 32'd11);
        access("R7 top", 16'hC000, 1'b0, 1'b1);

        // R8 and R9: shadow base with bank wrap.
        io_write(16'h123D, 8'hFE);
        io_write(16'h123C, 8'h00);
        readback("R9");
        io_write(16'h123B, 8'hCD);
        access("R8 shadow", 16'h8004, 1'b1, 1'b0);
        chk("R9 wrap", 32'(phys_addr), 32'({7'd0, 14'h0004}));
        io_write(16'h123B, 8'h45);
        access("R8 active", 16'h0004, 1'b1, 1'b0);
        chk("R8 active bank", 32'(phys_addr[20:14]), 32'd1);

        // R11: unrelated port and no strobe.
        io_write(16'h123A, 8'hFF);
        io_write(16'h023B, 8'h00);
        readback("R11");
        access("R11 no strobe", 16'h0004, 1'b0, 1'b0);

        // R10 and mixed: random traffic against the model.
        for (int i = 0; i < 600; i++) begin
            int k = int'($urandom_range(0, 9));
            if (k == 0) begin
                io_write(16'h123B, 8'($urandom));
                readback("R2");
            end else if (k == 1) begin
                io_write($urandom_range(0, 1) ? 16'h123C : 16'h123D, 8'($urandom));
                readback("R9");
            end else if (k == 2) begin
                io_write(16'($urandom), 8'($urandom));
                readback("R11");
            end else begin
                logic [15:0] a  = 16'($urandom);
                logic        rd = 1'($urandom);
                logic        wr = 1'($urandom);
                logic [21:0] e  = model(a, rd, wr);
                access(e[21] ? (m_ctrl[7:6] == 2'd3 ? "R7" : "R6") : "R10", a, rd, wr);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule